// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt requests from five sources: two active-low external pins, two timer overflow strobes and a serial-port request line. Software sets up a master enable, a per-source enable mask, a per-source level selection (high or low) and a per-pin trigger type through a small register port. The controller resolves competing requests and presents one request to the CPU, carrying a 16-bit vector address. It keeps track of which levels are in service, so a high-level source can interrupt a low-level handler, but nothing can interrupt a high-level handler.

The CPU accepts a presented vector by pulsing `irq_ack` while `irq_req` is high. That marks the level of the granted source as in service and clears the internal flag of that source, when it has one. A one-cycle `irq_reti` pulse at the end of a handler releases the level that was entered last. Each external pin can act on a falling edge, which is latched in a flag, or on a low level, which is not latched. Timer strobes are always latched. The serial line is a plain level that its own peripheral clears.

Top module: `irq2_ctrl`

## Requirements
- R1: After a synchronous reset, all four registers read 0, no level is in service, and `irq_req` is low.
- R2: Register address 0 holds the master enable at bit 7 and the source enables at bits 4..0. Address 1 holds the source levels at bits 4..0 (1 = high). Address 2 holds the edge-mode bits for pin 0 and pin 1 at bits 0 and 1, and the pin 0 and pin 1 edge flags at bits 3 and 2. Address 3 holds the timer 0 and timer 1 flags at bits 0 and 1. All other bits read 0. A write stores the writable fields, and the flags can be written too. The `reg_rdata` output follows `reg_addr` within the same cycle.
- R3: While the master enable is 0, `irq_req` stays low whatever the source enables hold.
- R4: A source whose enable bit is 0 never produces a request, even though its flag can still be read.
- R5: Source indices are pin 0 = 0, timer 0 = 1, pin 1 = 2, timer 1 = 3, serial = 4. Among candidates on the same level, the lowest index wins. The vector is 0x0003 + 8 × index, and it reads 0 while `irq_req` is low.
- R6: When no level is in service, a high-level candidate wins over any low-level candidate.
- R7: While only the low level is in service, a high-level candidate raises `irq_req`. Acknowledging it puts the high level in service as well.
- R8: While the high level is in service, `irq_req` stays low. While only the low level is in service, low-level candidates do not raise `irq_req`.
- R9: An `irq_reti` pulse releases the high level if it is in service, and otherwise releases the low level. Only one level is released per pulse.
- R10: A pin in edge mode sets its flag on a falling edge, and an acknowledge of that pin clears the flag. A pin in level mode requests while it is low and latches no flag.
- R11: A timer strobe sets its flag on the next clock edge, and an acknowledge of that timer clears the flag.
- R12: The serial request follows its input line, and an acknowledge does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_n | input | 2 | Active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow strobes, one cycle each |
| ser_req | input | 1 | Serial port request level |
| irq_ack | input | 1 | CPU accepts the presented vector |
| irq_reti | input | 1 | End of handler, releases one level |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 16 | Vector address of the presented source |

## Verification
The hardest state to reach is two nested levels in service while a low-level source is still pending. The stimulus first acknowledges one low-level timer while a second timer flag stays set. It then raises the high-level serial line and acknowledges it, and finally issues two separate return pulses. The request must stay low after the first pulse and return with the second timer's vector only after the second. A behavioural model in the bench tracks the flags and the in-service levels on every clock, so each cycle of these sequences is compared.

// File: rtl/irq2_pkg.sv
package irq2_pkg;

    localparam int NSRC = 5;
    localparam int IDXW = $clog2(NSRC);
    localparam int NPIN = 2;

    localparam logic [IDXW-1:0] SRC_PIN0 = IDXW'(0);
    localparam logic [IDXW-1:0] SRC_TMR0 = IDXW'(1);
    localparam logic [IDXW-1:0] SRC_PIN1 = IDXW'(2);
    localparam logic [IDXW-1:0] SRC_TMR1 = IDXW'(3);
    localparam logic [IDXW-1:0] SRC_SER  = IDXW'(4);

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_LEVEL  = 2'd1,
        RA_PINCTL = 2'd2,
        RA_TMRFLG = 2'd3
    } regsel_e;

    typedef struct packed {
        logic            valid;
        logic            hi;
        logic [IDXW-1:0] idx;
    } grant_t;

    function automatic logic [IDXW-1:0] lowest_set(input logic [NSRC-1:0] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction

    function automatic logic [NSRC-1:0] idx_onehot(input logic [IDXW-1:0] i);
        return NSRC'(1) << i;
    endfunction

endpackage

// File: rtl/irq2_regs.sv
module irq2_regs
    import irq2_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NPIN-1:0] ext_n,
    input  logic [NPIN-1:0] tmr_ovf,
    input  logic            ser_req,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] req,
    output logic [NSRC-1:0] pri,
    output logic            glb
);

    regsel_e         sel;
    logic            glb_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pri_q;
    logic [NPIN-1:0] mode_q;
    logic [NPIN-1:0] pflag;
    logic [NPIN-1:0] tflag;
    logic [NSRC-1:0] pend;

    assign sel = regsel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q  <= 1'b0;
            en_q   <= '0;
            pri_q  <= '0;
            mode_q <= '0;
        end else if (we) begin
            case (sel)
                RA_ENABLE: begin
                    glb_q <= wdata[DW-1];
                    en_q  <= wdata[NSRC-1:0];
                end
                RA_LEVEL:  pri_q  <= wdata[NSRC-1:0];
                RA_PINCTL: mode_q <= wdata[NPIN-1:0];
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_src
            logic prev_q;
            logic flag_q;
            logic tf_q;
            logic fall;

            assign fall = prev_q & ~ext_n[g];

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b1;
                    flag_q <= 1'b0;
                end else begin
                    prev_q <= ext_n[g];
                    if (fall && mode_q[g])
                        flag_q <= 1'b1;
                    else if (clr[2*g])
                        flag_q <= 1'b0;
                    else if (we && sel == RA_PINCTL)
                        flag_q <= wdata[NPIN+NPIN-1-g];
                end
            end

            always_ff @(posedge clk) begin
                if (rst)
                    tf_q <= 1'b0;
                else if (tmr_ovf[g])
                    tf_q <= 1'b1;
                else if (clr[2*g+1])
                    tf_q <= 1'b0;
                else if (we && sel == RA_TMRFLG)
                    tf_q <= wdata[g];
            end

            assign pflag[g]    = flag_q;
            assign tflag[g]    = tf_q;
            assign pend[2*g]   = mode_q[g] ? flag_q : ~ext_n[g];
            assign pend[2*g+1] = tf_q;

            // R10
            pin_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
                clr[2*g] && !(fall && mode_q[g]) |=> !flag_q);

            // R10
            level_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
                !mode_q[g] && !flag_q && !(we && sel == RA_PINCTL) |=> !flag_q);

            // R11
            tmr_set_chk: assert property (@(posedge clk) disable iff (rst)
                tmr_ovf[g] |=> tf_q);
        end
    endgenerate

    assign pend[SRC_SER] = ser_req;

    always_comb begin
        rdata = '0;
        case (sel)
            RA_ENABLE: begin
                rdata[DW-1]     = glb_q;
                rdata[NSRC-1:0] = en_q;
            end
            RA_LEVEL:  rdata[NSRC-1:0] = pri_q;
            RA_PINCTL: begin
                rdata[NPIN-1:0]      = mode_q;
                rdata[NPIN+1:NPIN]   = {pflag[0], pflag[1]};
            end
            RA_TMRFLG: rdata[NPIN-1:0] = tflag;
            default: ;
        endcase
    end

    assign req = pend & en_q & {NSRC{glb_q}};
    assign pri = pri_q;
    assign glb = glb_q;

endmodule

// File: rtl/irq2_arbiter.sv
module irq2_arbiter
    import irq2_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] pri,
    input  logic            act_hi,
    input  logic            act_lo,
    output grant_t          gnt
);

    logic [NSRC-1:0] hi_c;
    logic [NSRC-1:0] lo_c;

    assign hi_c = req & pri;
    assign lo_c = req & ~pri;

    always_comb begin
        gnt = '0;
        if (act_hi) begin
            gnt = '0;
        end else if (|hi_c) begin
            gnt.valid = 1'b1;
            gnt.hi    = 1'b1;
            gnt.idx   = lowest_set(hi_c);
        end else if (!act_lo && (|lo_c)) begin
            gnt.valid = 1'b1;
            gnt.hi    = 1'b0;
            gnt.idx   = lowest_set(lo_c);
        end
    end

endmodule

// File: rtl/irq2_levels.sv
module irq2_levels (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_hi,
    input  logic reti,
    output logic act_hi,
    output logic act_lo
);

    logic hi_q, lo_q;
    logic hi_d, lo_d;

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (reti) begin
            if (hi_q) hi_d = 1'b0;
            else      lo_d = 1'b0;
        end
        if (take) begin
            if (take_hi) hi_d = 1'b1;
            else         lo_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign act_hi = hi_q;
    assign act_lo = lo_q;

    // R9
    reti_pops_hi_chk: assert property (@(posedge clk) disable iff (rst)
        reti && hi_q && !take |=> !hi_q && $stable(lo_q));

    // R7
    take_hi_chk: assert property (@(posedge clk) disable iff (rst)
        take && take_hi |=> hi_q);

endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
    import irq2_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [15:0] VEC_BASE = 16'h0003,
    parameter logic [15:0] VEC_STEP = 16'h0008
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [1:0]    ext_n,
    input  logic [1:0]    tmr_ovf,
    input  logic          ser_req,
    input  logic          irq_ack,
    input  logic          irq_reti,
    output logic          irq_req,
    output logic [15:0]   irq_vec
);

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] pri;
    logic [NSRC-1:0] clr;
    logic            glb;
    logic            lv_hi, lv_lo;
    logic            take;
    grant_t          gnt;

    irq2_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ext_n   (ext_n),
        .tmr_ovf (tmr_ovf),
        .ser_req (ser_req),
        .clr     (clr),
        .req     (req),
        .pri     (pri),
        .glb     (glb)
    );

    irq2_arbiter u_arb (
        .req    (req),
        .pri    (pri),
        .act_hi (lv_hi),
        .act_lo (lv_lo),
        .gnt    (gnt)
    );

    assign take = irq_ack & gnt.valid;
    assign clr  = take ? idx_onehot(gnt.idx) : '0;

    irq2_levels u_lv (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_hi (gnt.hi),
        .reti    (irq_reti),
        .act_hi  (lv_hi),
        .act_lo  (lv_lo)
    );

    assign irq_req = gnt.valid;
    assign irq_vec = gnt.valid ? VEC_BASE + VEC_STEP * 16'(gnt.idx) : 16'h0000;

    // R8
    hi_busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        lv_hi |-> !irq_req);

    // R7
    lo_busy_hi_only_chk: assert property (@(posedge clk) disable iff (rst)
        lv_lo && irq_req |-> gnt.hi);

    // R3
    glb_off_chk: assert property (@(posedge clk) disable iff (rst)
        !glb |-> !irq_req);

    // R5
    clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));

    // R12
    ser_not_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        take && gnt.idx == SRC_SER |-> !clr[0] && !clr[1] && !clr[2] && !clr[3]);

endmodule

// File: tb/test_irq2_ctrl.sv
module test_irq2_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_req = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq2_ctrl i_irq2_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_n(ext_n),
        .tmr_ovf(tmr_ovf), .ser_req(ser_req), .irq_ack(irq_ack),
        .irq_reti(irq_reti), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // behavioural reference state
    bit       m_glb;
    bit [4:0] m_en, m_pri;
    bit [1:0] m_mode, m_pf, m_prev, m_tf;
    bit       m_hi, m_lo;

    function automatic bit m_pend(input int i);
        case (i)
            0: return m_mode[0] ? m_pf[0] : !ext_n[0];
            1: return m_tf[0];
            2: return m_mode[1] ? m_pf[1] : !ext_n[1];
            3: return m_tf[1];
            default: return ser_req;
        endcase
    endfunction

    function automatic int m_pick(output bit hi);
        hi = 0;
        if (m_hi) return -1;
        for (int i = 0; i < 5; i++)
            if (m_glb && m_en[i] && m_pri[i] && m_pend(i)) begin hi = 1; return i; end
        if (m_lo) return -1;
        for (int i = 0; i < 5; i++)
            if (m_glb && m_en[i] && !m_pri[i] && m_pend(i)) return i;
        return -1;
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {m_glb, 2'b00, m_en};
            2'd1: return {3'b000, m_pri};
            2'd2: return {4'h0, m_pf[0], m_pf[1], m_mode};
            default: return {6'd0, m_tf};
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_glb = 0; m_en = 0; m_pri = 0; m_mode = 0; m_pf = 0;
            m_prev = 2'b11; m_tf = 0; m_hi = 0; m_lo = 0;
        end else begin
            bit h;
            int g;
            bit take;
            g = m_pick(h);
            take = irq_ack && (g >= 0);
            for (int k = 0; k < 2; k++) begin
                if (m_prev[k] && !ext_n[k] && m_mode[k]) m_pf[k] = 1;
                else if (take && g == 2 * k) m_pf[k] = 0;
                else if (reg_we && reg_addr == 2'd2) m_pf[k] = reg_wdata[3 - k];
                if (tmr_ovf[k]) m_tf[k] = 1;
                else if (take && g == 2 * k + 1) m_tf[k] = 0;
                else if (reg_we && reg_addr == 2'd3) m_tf[k] = reg_wdata[k];
            end
            m_prev = ext_n;
            if (reg_we && reg_addr == 2'd0) begin m_glb = reg_wdata[7]; m_en = reg_wdata[4:0]; end
            if (reg_we && reg_addr == 2'd1) m_pri = reg_wdata[4:0];
            if (reg_we && reg_addr == 2'd2) m_mode = reg_wdata[1:0];
            if (irq_reti) begin
                if (m_hi) m_hi = 0; else m_lo = 0;
            end
            if (take) begin
                if (h) m_hi = 1; else m_lo = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R5 arbitration, R2 read path)
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit h;
            int g;
            g = m_pick(h);
            chk("R5 model req", {15'd0, irq_req}, {15'd0, g >= 0});
            chk("R5 model vec", irq_vec, (g >= 0) ? 16'(3 + 8 * g) : 16'h0000);
            chk("R2 model rdata", {8'h00, reg_rdata}, {8'h00, m_read(reg_addr)});
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        step();
        chk(tag, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic ack();   irq_ack = 1;  step(); irq_ack = 0;  endtask
    task automatic reti();  irq_reti = 1; step(); irq_reti = 0; endtask

    task automatic see(input string tag, input bit r, input logic [15:0] v);
        chk(tag, {15'd0, irq_req}, {15'd0, r});
        chk(tag, irq_vec, v);
    endtask

    initial begin
        step(3);
        rst = 0;
        step();
        // R1 reset state
        see("R1 idle", 0, 16'h0000);
        rd("R1 reg0", 2'd0, 8'h00);
        rd("R1 reg1", 2'd1, 8'h00);
        rd("R1 reg2", 2'd2, 8'h00);
        rd("R1 reg3", 2'd3, 8'h00);

        // R2 register map
        wr(2'd0, 8'hFF); rd("R2 enable", 2'd0, 8'h9F);
        wr(2'd1, 8'hFF); rd("R2 level", 2'd1, 8'h1F);
        wr(2'd2, 8'h0C); rd("R2 pinctl", 2'd2, 8'h0C);
        wr(2'd3, 8'h03); rd("R2 tmrflg", 2'd3, 8'h03);
        wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        rd("R2 cleared", 2'd3, 8'h00);

        // R3 master enable
        ser_req = 1;
        wr(2'd0, 8'h1F); step();
        see("R3 masked", 0, 16'h0000);
        wr(2'd0, 8'h9F);
        see("R3 unmasked", 1, 16'h0023);
        // R4 source enable
        wr(2'd0, 8'h8F);
        see("R4 serial off", 0, 16'h0000);
        ser_req = 0;

        // R5 order within one level
        wr(2'd0, 8'h9F);
        tmr_ovf = 2'b11; step(); tmr_ovf = 2'b00;
        ext_n = 2'b00; ser_req = 1; step();
        see("R5 pin0 first", 1, 16'h0003);
        ack();
        see("R8 low waits", 0, 16'h0000);
        reti();
        see("R10 level stays", 1, 16'h0003);
        ext_n[0] = 1; step();
        see("R5 timer0 next", 1, 16'h000B);
        ack();
        see("R8 low busy", 0, 16'h0000);
        reti();
        see("R5 pin1 next", 1, 16'h0013);
        ext_n = 2'b11; step();
        see("R5 timer1 next", 1, 16'h001B);
        ack(); reti();
        see("R5 serial last", 1, 16'h0023);
        ack(); reti();
        see("R12 serial kept", 1, 16'h0023);
        ser_req = 0; step();
        see("R12 serial gone", 0, 16'h0000);
        rd("R11 timers cleared", 2'd3, 8'h00);

        // R6 high beats low
        wr(2'd1, 8'h10);
        tmr_ovf = 2'b01; step(); tmr_ovf = 2'b00;
        ser_req = 1; step();
        see("R6 high wins", 1, 16'h0023);
        ack();
        see("R8 high busy", 0, 16'h0000);
        reti();
        see("R6 high again", 1, 16'h0023);
        ser_req = 0; step();
        see("R6 low after", 1, 16'h000B);

        // R7 nesting and R9 release order
        tmr_ovf = 2'b10; step(); tmr_ovf = 2'b00;
        ack();
        see("R8 timer1 waits", 0, 16'h0000);
        ser_req = 1; step();
        see("R7 preempt", 1, 16'h0023);
        ack();
        ser_req = 0; step();
        see("R8 nested quiet", 0, 16'h0000);
        reti();
        see("R9 low still busy", 0, 16'h0000);
        reti();
        see("R9 low released", 1, 16'h001B);
        ack(); reti();
        see("R9 all clear", 0, 16'h0000);
        reti();
        see("R9 idle reti", 0, 16'h0000);

        // R10 edge and level triggering
        wr(2'd1, 8'h00); wr(2'd0, 8'h81); wr(2'd2, 8'h01);
        ext_n[0] = 0; step();
        rd("R10 flag set", 2'd2, 8'h09);
        see("R10 edge req", 1, 16'h0003);
        ack();
        rd("R10 flag cleared", 2'd2, 8'h01);
        reti();
        see("R10 edge once", 0, 16'h0000);
        wr(2'd2, 8'h00);
        see("R10 level req", 1, 16'h0003);
        rd("R10 no latch", 2'd2, 8'h00);
        ext_n = 2'b11; step();
        see("R10 level gone", 0, 16'h0000);
        wr(2'd0, 8'h84); wr(2'd2, 8'h02);
        ext_n[1] = 0; step(); ext_n[1] = 1; step();
        see("R10 pin1 latched", 1, 16'h0013);
        ack(); reti();
        see("R10 pin1 done", 0, 16'h0000);

        // R11 timer flag without enable, then enabled
        wr(2'd0, 8'h80);
        tmr_ovf = 2'b10; step(); tmr_ovf = 2'b00;
        rd("R11 flag held", 2'd3, 8'h02);
        see("R4 timer1 off", 0, 16'h0000);
        wr(2'd0, 8'h88);
        see("R11 timer1 req", 1, 16'h001B);
        ack();
        rd("R11 ack clears", 2'd3, 8'h00);
        reti();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule